// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that retires one instruction on every rising clock edge. It executes six instructions: register add and register subtract, both with wrap-around; OR with a zero-extended immediate; word load; word store; and branch-if-equal. Any other opcode only advances the program counter. The core holds the program counter and a register file with 32 entries of 32 bits. Instruction memory and data memory are small internal word arrays. Both read combinationally. Data memory and the register file are written on the same clock edge that advances the program counter.

Memories are loaded through a word-wide load port while the core is held in reset. After reset is released, the core runs from address 0. Two observation outputs let the surroundings follow execution: the current program counter, and a third, combinational read port on the register file.

Instruction fields sit at fixed positions:

- opcode [31:26]
- first source [25:21]
- second source or I-format destination [20:16]
- R-format destination [15:11]
- function [5:0]
- immediate [15:0]

Opcodes:

| Instruction | Opcode |
|---|---|
| R-format | 000000 |
| OR immediate | 001101 |
| load | 100011 |
| store | 101011 |
| branch-if-equal | 000100 |

R-format function codes are 100001 for add and 100011 for subtract.

Top module: `rsc_core`

## Requirements
- R1: While `rst_n` is low, and for the first rising edge after it is released, `pc_o` is 0.
- R2: An R-format instruction with function 100001 writes rs+rt into rd, and one with function 100011 writes rs-rt into rd. Both results are taken modulo 2^32.
- R3: OR immediate (001101) writes rs OR {16'b0, imm} into rt. Immediate bit 15 is not sign-extended.
- R4: Load (100011) writes into rt the data word at word index (rs + sign-extended imm)[7:2]. Negative offsets are allowed.
- R5: Store (101011) writes rt into data word (rs + sign-extended imm)[7:2] and writes no register. A later load from that address returns the stored value.
- R6: Branch-if-equal (000100) sets the next PC to PC+4+(sign-extended imm shifted left by 2) when rs equals rt, and to PC+4 otherwise. It writes no register and no memory.
- R7: Register 0 always reads as 0. Writes that target it are ignored.
- R8: An unknown opcode, or an R-format instruction with any other function code, only advances the PC by 4. No register or memory changes.
- R9: Every instruction other than branch-if-equal advances the PC by exactly 4 per clock.
- R10: While `ld_we` is high, `ld_data` is written to word `ld_addr` of instruction memory (`ld_sel`=0) or of data memory (`ld_sel`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_we | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | Load-port target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Load-port word index |
| ld_data | input | 32 | Load-port write data |
| dbg_addr | input | 5 | Register index for the observation read port |
| dbg_data | output | 32 | Combinational contents of register `dbg_addr` |
| pc_o | output | 32 | Current program counter |

## Verification
The hardest behaviour to reach from the ports is a backward branch that is taken. It needs a loop whose counter reaches zero only after several passes, so both the taken and not-taken outcomes of one branch appear in a single run. The program builds a three-pass countdown loop. Inside it, a forward branch-if-equal exits on zero and an always-true branch jumps back four words.

A separate reference model inside the bench steps the same program and predicts every program counter value in sequence. Final register contents then confirm the loop total, the store-then-load round trip, and that writes to register 0, unknown opcodes and unknown function codes left no trace.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam logic [5:0] OP_RFMT = 6'b000000;
  localparam logic [5:0] OP_LDW  = 6'b100011;
  localparam logic [5:0] OP_STW  = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_ORI  = 6'b001101;

  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUBU = 6'b100011;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    dst_rd;
    logic    src_imm;
    logic    ext_zero;
    logic    mem_wr;
    logic    mem_to_reg;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
  import rsc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (op)
      OP_RFMT: begin
        if (funct == FN_ADDU) begin
          ctrl.reg_wr = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.reg_wr = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.reg_wr   = 1'b1;
        ctrl.src_imm  = 1'b1;
        ctrl.ext_zero = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      OP_LDW: begin
        ctrl.reg_wr     = 1'b1;
        ctrl.src_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_STW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
  import rsc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_c
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
  assign rd_c = (ra_c == '0) ? '0 : regs[ra_c];

endmodule

// File: rtl/rsc_wordmem.sv
module rsc_wordmem #(
  parameter int W  = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd = mem[ra];

endmodule

// File: rtl/rsc_core.sv
module rsc_core
  import rsc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int NREG    = 32,
  localparam int XW     = 32,
  localparam int RA_W   = $clog2(NREG),
  localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic             ld_sel,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XW-1:0]    ld_data,
  input  logic [RA_W-1:0]  dbg_addr,
  output logic [XW-1:0]    dbg_data,
  output logic [XW-1:0]    pc_o
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];

  // program counter
  logic [XW-1:0] pc_q, pc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end
  assign pc_o = pc_q;

  // instruction fetch
  logic [XW-1:0] instr;
  logic          imem_we;

  assign imem_we = ld_we && !ld_sel;

  rsc_wordmem #(.W(XW), .AW(IMEM_AW)) u_imem (
    .clk (clk),
    .we  (imem_we),
    .wa  (ld_addr[IMEM_AW-1:0]),
    .wd  (ld_data),
    .ra  (pc_q[IMEM_AW+1:2]),
    .rd  (instr)
  );

  // field split
  logic [5:0]    f_op, f_funct;
  logic [RA_W-1:0] f_rs, f_rt, f_rd;
  logic [15:0]   f_imm;

  assign f_op    = instr[31:26];
  assign f_rs    = instr[21+RA_W-1:21];
  assign f_rt    = instr[16+RA_W-1:16];
  assign f_rd    = instr[11+RA_W-1:11];
  assign f_funct = instr[5:0];
  assign f_imm   = instr[15:0];

  // control
  ctrl_t ctrl;

  rsc_decode u_dec (
    .op    (f_op),
    .funct (f_funct),
    .ctrl  (ctrl)
  );

  // register file
  logic [XW-1:0]   rs_val, rt_val, wb_val;
  logic [RA_W-1:0] rf_wa;
  logic            rf_we;

  assign rf_wa = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_we = run && ctrl.reg_wr;

  rsc_regfile #(.W(XW), .NREG(NREG)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (wb_val),
    .ra_a (f_rs),
    .rd_a (rs_val),
    .ra_b (f_rt),
    .rd_b (rt_val),
    .ra_c (dbg_addr),
    .rd_c (dbg_data)
  );

  // extender and ALU
  logic [XW-1:0] imm_sx, imm_ext, alu_b, alu_y;
  logic          alu_zero;

  assign imm_sx  = {{(XW-16){f_imm[15]}}, f_imm};
  assign imm_ext = ctrl.ext_zero ? {{(XW-16){1'b0}}, f_imm} : imm_sx;
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  rsc_alu #(.W(XW)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: the load port takes priority over the core
  logic               dmem_we_core, dmem_we, ld_dmem;
  logic [DMEM_AW-1:0] dmem_wa;
  logic [XW-1:0]      dmem_wd, dmem_rd;

  assign ld_dmem      = ld_we && ld_sel;
  assign dmem_we_core = run && ctrl.mem_wr && !ld_dmem;
  assign dmem_we      = ld_dmem || dmem_we_core;
  assign dmem_wa      = ld_dmem ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
  assign dmem_wd      = ld_dmem ? ld_data : rt_val;

  rsc_wordmem #(.W(XW), .AW(DMEM_AW)) u_dmem (
    .clk (clk),
    .we  (dmem_we),
    .wa  (dmem_wa),
    .wd  (dmem_wd),
    .ra  (alu_y[DMEM_AW+1:2]),
    .rd  (dmem_rd)
  );

  assign wb_val = ctrl.mem_to_reg ? dmem_rd : alu_y;

  // next PC
  logic [XW-1:0] pc_seq, pc_tgt;

  assign pc_seq = pc_q + XW'(4);
  assign pc_tgt = pc_seq + {imm_sx[XW-3:0], 2'b00};

  always_comb begin
    if (ctrl.is_branch && alu_zero) pc_d = pc_tgt;
    else                            pc_d = pc_seq;
  end

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], instr[25:21+RA_W], instr[20:16+RA_W],
                         instr[15:11+RA_W], pc_q[1:0], alu_y[XW-1:DMEM_AW+2],
                         alu_y[1:0], ld_addr};

endmodule

// File: rtl/rsc_core_chk.sv
module rsc_core_chk
  import rsc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        rf_we,
  input logic        dmem_we_core,
  input logic [4:0]  dbg_addr,
  input logic [31:0] dbg_data
);

  logic [5:0] op;
  logic       known_op;
  assign op = instr[31:26];
  assign known_op = (op == OP_RFMT) || (op == OP_LDW) || (op == OP_STW) ||
                    (op == OP_BEQ) || (op == OP_ORI);

  // R1
  pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pc_q == 32'd0);

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && (op != OP_BEQ) |=> pc_q == $past(pc_q) + 32'd4);

  // R6
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && (op == OP_BEQ) && (rs_val == rt_val) |=>
      pc_q == $past(pc_q) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  // R6
  beq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && (op == OP_BEQ) && (rs_val != rt_val) |=> pc_q == $past(pc_q) + 32'd4);

  // R5
  store_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && ((op == OP_STW) || (op == OP_BEQ)) |-> !rf_we);

  // R5
  mem_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we_core |-> run && (op == OP_STW));

  // R8
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !known_op |-> !rf_we && !dmem_we_core);

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == 5'd0) |-> dbg_data == 32'd0);

endmodule

bind rsc_core rsc_core_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .pc_q         (pc_q),
  .instr        (instr),
  .rs_val       (rs_val),
  .rt_val       (rt_val),
  .rf_we        (rf_we),
  .dmem_we_core (dmem_we_core),
  .dbg_addr     (dbg_addr),
  .dbg_data     (dbg_data)
);

// File: tb/rsc_core_test.sv
module rsc_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we, ld_sel;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [4:0]  dbg_addr;
  logic [31:0] dbg_data, pc_o;

  always #5 clk = ~clk;

  rsc_core uut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .pc_o(pc_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  logic [31:0] m_imem [64];
  logic [31:0] m_dmem [64];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;

  // scoreboard queue of expected PCs with requirement tags
  logic [31:0] exp_pc [$];
  string       exp_tag [$];
  bit          mon_live = 0;

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_word(input logic sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = 6'(idx); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
    if (sel) m_dmem[idx] = d;
    else     m_imem[idx] = d;
  endtask

  // one instruction of the reference model, then push the predicted PC
  task automatic model_step();
    logic [31:0] ins, sx, zx, a, b, nxt;
    logic [5:0]  op;
    int          rs, rt, rd;
    string       tag;
    ins = m_imem[m_pc[7:2]];
    op  = ins[31:26];
    rs  = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx  = {{16{ins[15]}}, ins[15:0]};
    zx  = {16'd0, ins[15:0]};
    a   = m_reg[rs]; b = m_reg[rt];
    nxt = m_pc + 32'd4;
    tag = "R9";
    if (op == 6'b000000 && ins[5:0] == 6'b100001)      begin if (rd != 0) m_reg[rd] = a + b; end
    else if (op == 6'b000000 && ins[5:0] == 6'b100011) begin if (rd != 0) m_reg[rd] = a - b; end
    else if (op == 6'b001101) begin if (rt != 0) m_reg[rt] = a | zx; end
    else if (op == 6'b100011) begin logic [31:0] ad; ad = a + sx; if (rt != 0) m_reg[rt] = m_dmem[ad[7:2]]; end
    else if (op == 6'b101011) begin logic [31:0] ad; ad = a + sx; m_dmem[ad[7:2]] = b; end
    else if (op == 6'b000100) begin tag = "R6"; if (a == b) nxt = nxt + {sx[29:0], 2'b00}; end
    else tag = "R8";
    m_pc = nxt;
    exp_pc.push_back(nxt);
    exp_tag.push_back(tag);
  endtask

  // monitor: compare PC every cycle once the core starts moving
  always @(negedge clk) begin
    if (rst_n && exp_pc.size() > 0 && (mon_live || pc_o != 32'd0)) begin
      mon_live = 1;
      check({exp_tag.pop_front(), " pc"}, pc_o, exp_pc.pop_front());
    end
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] prog [23];
    string       rtag [12];
    rst_n = 1'b0; ld_we = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0; dbg_addr = '0;
    for (int i = 0; i < 64; i++) begin m_imem[i] = '0; m_dmem[i] = '0; end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;

    prog[0]  = enc_i(6'b001101, 0, 1, 16'h0005);          // r1 = 5
    prog[1]  = enc_i(6'b001101, 0, 2, 16'h8000);          // r2 = 0x8000 zero-extended
    prog[2]  = enc_r(6'b100001, 1, 2, 3);                 // r3 = r1 + r2
    prog[3]  = enc_r(6'b100011, 0, 1, 4);                 // r4 = 0 - 5 wraps
    prog[4]  = enc_i(6'b001101, 0, 5, 16'h0010);          // r5 = 16
    prog[5]  = enc_i(6'b101011, 5, 3, 4);                 // store r3 at 20
    prog[6]  = enc_i(6'b100011, 5, 6, -4);                // load 12 (negative offset)
    prog[7]  = enc_i(6'b100011, 5, 7, 4);                 // load 20
    prog[8]  = enc_i(6'b001101, 1, 0, 16'h00FF);          // write r0 ignored
    prog[9]  = enc_r(6'b100001, 1, 1, 0);                 // write r0 ignored
    prog[10] = {6'b111111, 5'd1, 5'd1, 16'hFFFF};         // unknown opcode
    prog[11] = enc_r(6'b100000, 1, 1, 1);                 // unknown function
    prog[12] = enc_i(6'b000100, 1, 2, 5);                 // not taken
    prog[13] = enc_i(6'b001101, 0, 8, 3);                 // r8 = 3
    prog[14] = enc_i(6'b001101, 0, 10, 1);                // r10 = 1
    prog[15] = enc_i(6'b001101, 0, 9, 0);                 // r9 = 0
    prog[16] = enc_r(6'b100001, 9, 1, 9);                 // r9 += 5
    prog[17] = enc_r(6'b100011, 8, 10, 8);                // r8 -= 1
    prog[18] = enc_i(6'b000100, 8, 0, 1);                 // exit on zero
    prog[19] = enc_i(6'b000100, 0, 0, -4);                // back to 16
    prog[20] = enc_i(6'b101011, 0, 9, 0);                 // store r9 at 0
    prog[21] = enc_i(6'b100011, 0, 11, 0);                // r11 = load 0
    prog[22] = enc_i(6'b000100, 0, 0, -1);                // spin

    // R10: preload both memories through the load port
    for (int i = 0; i < 23; i++) load_word(1'b0, i, prog[i]);
    load_word(1'b1, 3, 32'hCAFEF00D);
    load_word(1'b1, 5, 32'h0);
    load_word(1'b1, 0, 32'h0);

    for (int s = 0; s < 40; s++) model_step();

    @(negedge clk);
    check("R1 pc in reset", pc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pc after release", pc_o, 32'd0);

    for (int c = 0; c < 500 && exp_pc.size() > 0; c++) @(negedge clk);
    if (exp_pc.size() > 0) begin
      n_bad++;
      $display("FAIL R9: got %0d pending expected 0 pending", exp_pc.size());
    end

    rtag[0] = "R7"; rtag[1] = "R3/R8"; rtag[2] = "R3"; rtag[3] = "R2";
    rtag[4] = "R2"; rtag[5] = "R3"; rtag[6] = "R4/R10"; rtag[7] = "R5";
    rtag[8] = "R6"; rtag[9] = "R6"; rtag[10] = "R3"; rtag[11] = "R5";
    for (int r = 0; r < 12; r++) begin
      dbg_addr = 5'(r);
      #1;
      check({rtag[r], " reg"}, dbg_data, m_reg[r]);
    end
    // explicit values from the requirements
    dbg_addr = 5'd4;  #1; check("R2 wrap", dbg_data, 32'hFFFFFFFB);
    dbg_addr = 5'd2;  #1; check("R3 zero-ext", dbg_data, 32'h00008000);
    dbg_addr = 5'd9;  #1; check("R6 loop sum", dbg_data, 32'd15);
    dbg_addr = 5'd6;  #1; check("R4 neg offset", dbg_data, 32'hCAFEF00D);
    check("R6 spin pc", pc_o, 32'd88);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule